// File: doc/BRIEF.md
# Sub-Word Operand Select and Merge

This block sits beside a 32-bit integer ALU. It prepares narrow operands on the way in and merges narrow results on the way out. On the source side it takes two 32-bit register values. For each one it picks the whole word, one of the four bytes or one of the two 16-bit halves, then widens the chosen field to 32 bits by zero fill or by sign fill. On the destination side it takes the ALU result and the current contents of the destination register. It writes the low bits of the result into the chosen byte or half of the destination. The remaining bits are cleared, sign-filled above the field with zeros below it, or kept from the old destination value.

The source path and the destination path are independent. Each has its own strobe, and both are registered with a one-cycle latency. The select code and fill policy are presented with the data on every transaction. The ALU and any instruction decoding stay outside the block.

Top module: `subword_sel_merge`

## Requirements
- R1: A 3-bit select code picks the field: codes 0, 1, 2, 3 pick bits 7:0, 15:8, 23:16, 31:24; code 4 picks bits 15:0; code 5 picks bits 31:16; code 6 and code 7 pick all 32 bits.
- R2: A source field selected with its extend flag low is zero-extended to 32 bits.
- R3: A source field of 8 or 16 bits selected with its extend flag high is sign-extended from its top bit. The flag has no effect when all 32 bits are selected.
- R4: The destination field picked by the destination select code receives the low 8, 16 or 32 bits of the ALU result.
- R5: Fill code 0 clears every destination bit outside the field.
- R6: Fill code 1 copies the field's top bit into every bit above the field and clears every bit below it.
- R7: Fill codes 2 and 3 keep every bit outside the field from the old destination value.
- R8: Each path's outputs update in the cycle after its input strobe and its output strobe is high for exactly that one cycle. With the strobe low, the outputs hold their values whatever the other inputs do.
- R9: After synchronous reset, both output strobes are low and all output data are zero.
- R10: With destination select code 6, the output equals the ALU result whatever the fill code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_valid | input | 1 | Source transaction strobe |
| src_a | input | 32 | First source register value |
| src_b | input | 32 | Second source register value |
| src_a_sel | input | 3 | Field select for the first source |
| src_b_sel | input | 3 | Field select for the second source |
| src_a_sext | input | 1 | Sign-extend the first source field |
| src_b_sext | input | 1 | Sign-extend the second source field |
| opnd_valid | output | 1 | Formatted operands valid |
| opnd_a | output | 32 | Formatted first operand |
| opnd_b | output | 32 | Formatted second operand |
| res_valid | input | 1 | Destination transaction strobe |
| alu_res | input | 32 | ALU result to merge |
| dst_old | input | 32 | Current destination register value |
| dst_sel | input | 3 | Destination field select |
| dst_fill | input | 2 | Fill policy for bits outside the field |
| merge_valid | output | 1 | Merged result valid |
| merge_out | output | 32 | Merged destination value |

## Verification
The properties assume that reset is asserted before the first strobe, and that the select, extend and fill inputs are valid whenever a strobe is high. The bench drives every control input to a known value on every cycle. It raises each strobe for a single cycle with an idle cycle between transactions. In the idle cycles it changes the data and control inputs, so that any update without a strobe is seen at the outputs. The bench uses all eight select codes and all four fill codes. Its operand values have sub-fields whose top bit is set and sub-fields whose top bit is clear.

// File: rtl/sws_pkg.sv
package sws_pkg;

    localparam int DW       = 32;
    localparam int SEL_W    = 3;
    localparam int FILL_W   = 2;
    localparam int LSB_W    = $clog2(DW);
    localparam int BYTE_W   = 8;
    localparam int HALF_W   = 16;
    localparam int NUM_SRC  = 2;

    localparam logic [SEL_W-1:0] SEL_HALF_LO = 3'd4;
    localparam logic [SEL_W-1:0] SEL_HALF_HI = 3'd5;
    localparam logic [SEL_W-1:0] SEL_FULL    = 3'd6;

    typedef enum logic [1:0] {
        FK_BYTE = 2'd0,
        FK_HALF = 2'd1,
        FK_FULL = 2'd2
    } fkind_e;

    typedef enum logic [FILL_W-1:0] {
        FILL_ZERO = 2'd0,
        FILL_SIGN = 2'd1,
        FILL_KEEP = 2'd2,
        FILL_KEEP_ALT = 2'd3
    } fill_e;

    typedef struct packed {
        fkind_e            kind;
        logic [LSB_W-1:0]  lsb;
    } field_t;

    function automatic field_t decode_sel(input logic [SEL_W-1:0] sel);
        field_t f;
        f.kind = FK_FULL;
        f.lsb  = '0;
        if (sel[2] == 1'b0) begin
            f.kind = FK_BYTE;
            f.lsb  = LSB_W'({sel[1:0], 3'b000});
        end else if (sel == SEL_HALF_LO) begin
            f.kind = FK_HALF;
            f.lsb  = '0;
        end else if (sel == SEL_HALF_HI) begin
            f.kind = FK_HALF;
            f.lsb  = LSB_W'(HALF_W);
        end
        return f;
    endfunction

    function automatic logic [DW-1:0] width_mask(input fkind_e k);
        logic [DW-1:0] m;
        case (k)
            FK_BYTE: m = DW'({BYTE_W{1'b1}});
            FK_HALF: m = DW'({HALF_W{1'b1}});
            default: m = '1;
        endcase
        return m;
    endfunction

    function automatic logic field_top(input logic [DW-1:0] v, input fkind_e k);
        logic t;
        case (k)
            FK_BYTE: t = v[BYTE_W-1];
            FK_HALF: t = v[HALF_W-1];
            default: t = v[DW-1];
        endcase
        return t;
    endfunction

endpackage

// File: rtl/sws_src_lane.sv
module sws_src_lane
    import sws_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  logic [DW-1:0]        src,
    input  logic [SEL_W-1:0]     sel,
    input  logic                 sext,
    output logic [DW-1:0]        opnd
);

    field_t        fld;
    logic [DW-1:0] shifted;
    logic [DW-1:0] wmask;
    logic [DW-1:0] narrow;
    logic [DW-1:0] widened;
    logic          top_bit;

    always_comb begin
        fld     = decode_sel(sel);
        wmask   = width_mask(fld.kind);
        shifted = src >> fld.lsb;
        narrow  = shifted & wmask;
        top_bit = field_top(shifted, fld.kind);
        if (sext && (fld.kind != FK_FULL) && top_bit) begin
            widened = narrow | ~wmask;
        end else begin
            widened = narrow;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            opnd <= '0;
        end else if (load) begin
            opnd <= widened;
        end
    end

endmodule

// File: rtl/sws_dst_merge.sv
module sws_dst_merge
    import sws_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  logic [DW-1:0]        res,
    input  logic [DW-1:0]        old,
    input  logic [SEL_W-1:0]     sel,
    input  logic [FILL_W-1:0]    fill,
    output logic [DW-1:0]        merged
);

    field_t        fld;
    fill_e         pol;
    logic [DW-1:0] wmask;
    logic [DW-1:0] field_mask;
    logic [DW-1:0] below_mask;
    logic [DW-1:0] above_mask;
    logic [DW-1:0] placed;
    logic [DW-1:0] next_val;
    logic          top_bit;

    always_comb begin
        fld        = decode_sel(sel);
        pol        = fill_e'(fill);
        wmask      = width_mask(fld.kind);
        field_mask = wmask << fld.lsb;
        below_mask = (DW'(1) << fld.lsb) - DW'(1);
        above_mask = ~(field_mask | below_mask);
        placed     = (res & wmask) << fld.lsb;
        top_bit    = field_top(res, fld.kind);
        case (pol)
            FILL_ZERO: next_val = placed;
            FILL_SIGN: next_val = top_bit ? (placed | above_mask) : placed;
            default:   next_val = placed | (old & ~field_mask);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            merged <= '0;
        end else if (load) begin
            merged <= next_val;
        end
    end

endmodule

// File: rtl/subword_sel_merge.sv
module subword_sel_merge
    import sws_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              src_valid,
    input  logic [31:0]       src_a,
    input  logic [31:0]       src_b,
    input  logic [2:0]        src_a_sel,
    input  logic [2:0]        src_b_sel,
    input  logic              src_a_sext,
    input  logic              src_b_sext,
    output logic              opnd_valid,
    output logic [31:0]       opnd_a,
    output logic [31:0]       opnd_b,
    input  logic              res_valid,
    input  logic [31:0]       alu_res,
    input  logic [31:0]       dst_old,
    input  logic [2:0]        dst_sel,
    input  logic [1:0]        dst_fill,
    output logic              merge_valid,
    output logic [31:0]       merge_out
);

    logic [DW-1:0]    lane_src  [NUM_SRC];
    logic [SEL_W-1:0] lane_sel  [NUM_SRC];
    logic             lane_sext [NUM_SRC];
    logic [DW-1:0]    lane_out  [NUM_SRC];

    assign lane_src[0]  = src_a;
    assign lane_src[1]  = src_b;
    assign lane_sel[0]  = src_a_sel;
    assign lane_sel[1]  = src_b_sel;
    assign lane_sext[0] = src_a_sext;
    assign lane_sext[1] = src_b_sext;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_lane
        sws_src_lane u_lane (
            .clk  (clk),
            .rst  (rst),
            .load (src_valid),
            .src  (lane_src[i]),
            .sel  (lane_sel[i]),
            .sext (lane_sext[i]),
            .opnd (lane_out[i])
        );
    end

    assign opnd_a = lane_out[0];
    assign opnd_b = lane_out[1];

    sws_dst_merge u_merge (
        .clk    (clk),
        .rst    (rst),
        .load   (res_valid),
        .res    (alu_res),
        .old    (dst_old),
        .sel    (dst_sel),
        .fill   (dst_fill),
        .merged (merge_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            opnd_valid  <= 1'b0;
            merge_valid <= 1'b0;
        end else begin
            opnd_valid  <= src_valid;
            merge_valid <= res_valid;
        end
    end

endmodule

// File: rtl/sws_checker.sv
module sws_checker (
    input logic        clk,
    input logic        rst,
    input logic        src_valid,
    input logic [31:0] src_a,
    input logic [2:0]  src_a_sel,
    input logic        src_a_sext,
    input logic        opnd_valid,
    input logic [31:0] opnd_a,
    input logic        res_valid,
    input logic [31:0] alu_res,
    input logic [31:0] dst_old,
    input logic [2:0]  dst_sel,
    input logic [1:0]  dst_fill,
    input logic        merge_valid,
    input logic [31:0] merge_out
);

    AST_OPND_LATENCY: assert property (@(posedge clk) disable iff (rst)
        src_valid |=> opnd_valid); // R8

    AST_MERGE_PULSE: assert property (@(posedge clk) disable iff (rst)
        !res_valid |=> !merge_valid); // R8

    AST_OPND_HOLD: assert property (@(posedge clk) disable iff (rst)
        !src_valid |=> $stable(opnd_a)); // R8

    AST_FULL_PASS: assert property (@(posedge clk) disable iff (rst)
        (src_valid && src_a_sel[2:1] == 2'b11) |=> opnd_a == $past(src_a)); // R1

    AST_BYTE_ZEXT: assert property (@(posedge clk) disable iff (rst)
        (src_valid && !src_a_sel[2] && !src_a_sext) |=> opnd_a[31:8] == 24'd0); // R2

    AST_BYTE_SEXT: assert property (@(posedge clk) disable iff (rst)
        (src_valid && !src_a_sel[2] && src_a_sext) |=> opnd_a[31:8] == {24{opnd_a[7]}}); // R3

    AST_FILL_ZERO: assert property (@(posedge clk) disable iff (rst)
        (res_valid && dst_fill == 2'd0 && dst_sel == 3'd0) |=> merge_out[31:8] == 24'd0); // R5

    AST_FILL_SIGN: assert property (@(posedge clk) disable iff (rst)
        (res_valid && dst_fill == 2'd1 && dst_sel == 3'd4) |=> merge_out[31:16] == {16{merge_out[15]}}); // R6

    AST_FILL_KEEP: assert property (@(posedge clk) disable iff (rst)
        (res_valid && dst_fill[1] && dst_sel == 3'd5) |=> merge_out[15:0] == $past(dst_old[15:0])); // R7

    AST_FULL_MERGE: assert property (@(posedge clk) disable iff (rst)
        (res_valid && dst_sel == 3'd6) |=> merge_out == $past(alu_res)); // R10

endmodule

bind subword_sel_merge sws_checker u_sws_checker (
    .clk         (clk),
    .rst         (rst),
    .src_valid   (src_valid),
    .src_a       (src_a),
    .src_a_sel   (src_a_sel),
    .src_a_sext  (src_a_sext),
    .opnd_valid  (opnd_valid),
    .opnd_a      (opnd_a),
    .res_valid   (res_valid),
    .alu_res     (alu_res),
    .dst_old     (dst_old),
    .dst_sel     (dst_sel),
    .dst_fill    (dst_fill),
    .merge_valid (merge_valid),
    .merge_out   (merge_out)
);

// File: tb/subword_sel_merge_tb.sv
module subword_sel_merge_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        src_valid = 1'b0;
    logic [31:0] src_a = '0, src_b = '0;
    logic [2:0]  src_a_sel = 3'd6, src_b_sel = 3'd6;
    logic        src_a_sext = 1'b0, src_b_sext = 1'b0;
    logic        opnd_valid;
    logic [31:0] opnd_a, opnd_b;
    logic        res_valid = 1'b0;
    logic [31:0] alu_res = '0, dst_old = '0;
    logic [2:0]  dst_sel = 3'd6;
    logic [1:0]  dst_fill = 2'd2;
    logic        merge_valid;
    logic [31:0] merge_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [63:0] q_src[$];
    string       q_src_tag[$];
    logic [31:0] q_dst[$];
    string       q_dst_tag[$];

    always #10 clk = ~clk;

    subword_sel_merge u_dut (
        .clk(clk), .rst(rst),
        .src_valid(src_valid), .src_a(src_a), .src_b(src_b),
        .src_a_sel(src_a_sel), .src_b_sel(src_b_sel),
        .src_a_sext(src_a_sext), .src_b_sext(src_b_sext),
        .opnd_valid(opnd_valid), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .res_valid(res_valid), .alu_res(alu_res), .dst_old(dst_old),
        .dst_sel(dst_sel), .dst_fill(dst_fill),
        .merge_valid(merge_valid), .merge_out(merge_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Field geometry per select code: start bit and width in bits.
    function automatic void geom(input logic [2:0] sel, output int lo, output int w);
        if (sel < 3'd4) begin lo = 8 * int'(sel); w = 8; end
        else if (sel == 3'd4) begin lo = 0; w = 16; end
        else if (sel == 3'd5) begin lo = 16; w = 16; end
        else begin lo = 0; w = 32; end
    endfunction

    function automatic logic [31:0] model_src(input logic [31:0] x, input logic [2:0] sel, input logic sx);
        int lo, w;
        logic [63:0] v;
        geom(sel, lo, w);
        v = 64'(x) >> lo;
        v = v & ((64'd1 << w) - 64'd1);
        if (sx && w < 32 && v[w-1]) v = v | ~((64'd1 << w) - 64'd1);
        return v[31:0];
    endfunction

    function automatic logic [31:0] model_dst(input logic [31:0] r, input logic [31:0] o,
                                              input logic [2:0] sel, input logic [1:0] fill);
        int lo, w;
        logic [63:0] fm, put, res;
        geom(sel, lo, w);
        fm  = ((64'd1 << w) - 64'd1) << lo;
        put = (64'(r) << lo) & fm;
        if (fill == 2'd0) res = put;
        else if (fill == 2'd1) res = r[w-1] ? (put | ~((64'd1 << (lo + w)) - 64'd1)) : put;
        else res = put | (64'(o) & ~fm);
        return res[31:0];
    endfunction

    task automatic send_src(input logic [31:0] a, input logic [31:0] b,
                            input logic [2:0] sa, input logic [2:0] sb,
                            input logic xa, input logic xb, input string tag);
        @(negedge clk);
        src_a = a; src_b = b; src_a_sel = sa; src_b_sel = sb;
        src_a_sext = xa; src_b_sext = xb; src_valid = 1'b1;
        q_src.push_back({model_src(a, sa, xa), model_src(b, sb, xb)});
        q_src_tag.push_back(tag);
        @(negedge clk);
        src_valid = 1'b0;
        src_a = ~a; src_b = ~b; src_a_sel = sa + 3'd1; src_a_sext = ~xa;
    endtask

    task automatic send_dst(input logic [31:0] r, input logic [31:0] o,
                            input logic [2:0] s, input logic [1:0] f, input string tag);
        @(negedge clk);
        alu_res = r; dst_old = o; dst_sel = s; dst_fill = f; res_valid = 1'b1;
        q_dst.push_back(model_dst(r, o, s, f));
        q_dst_tag.push_back(tag);
        @(negedge clk);
        res_valid = 1'b0;
        alu_res = ~r; dst_old = ~o; dst_sel = s + 3'd1; dst_fill = f + 2'd1;
    endtask

    // Monitor: pops the scoreboard whenever a result strobe is seen.
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (opnd_valid) begin
                if (q_src.size() == 0) begin
                    check("R8 unexpected operand strobe", 32'd1, 32'd0);
                end else begin
                    logic [63:0] e;
                    string t;
                    e = q_src.pop_front();
                    t = q_src_tag.pop_front();
                    check({t, " opnd_a"}, opnd_a, e[63:32]);
                    check({t, " opnd_b"}, opnd_b, e[31:0]);
                end
            end
            if (merge_valid) begin
                if (q_dst.size() == 0) begin
                    check("R8 unexpected merge strobe", 32'd1, 32'd0);
                end else begin
                    logic [31:0] e;
                    string t;
                    e = q_dst.pop_front();
                    t = q_dst_tag.pop_front();
                    check({t, " merge_out"}, merge_out, e);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] pat;
        logic [31:0] last_a, last_b, last_m;
        string tag;
        pat = 32'hF182_7CA5;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9: reset state
        check("R9 opnd_valid", {31'd0, opnd_valid}, 32'd0);
        check("R9 merge_valid", {31'd0, merge_valid}, 32'd0);
        check("R9 opnd_a", opnd_a, 32'd0);
        check("R9 opnd_b", opnd_b, 32'd0);
        check("R9 merge_out", merge_out, 32'd0);

        // R1 R2 R3: every select code, zero fill on a, sign fill on b
        for (int s = 0; s < 8; s++) begin
            send_src(pat, pat, 3'(s), 3'(s), 1'b0, 1'b1, (s >= 6) ? "R1 R3 full" : "R1 R2 R3");
        end
        send_src(32'h7FFF_0000, 32'h0012_0080, 3'd5, 3'd2, 1'b1, 1'b1, "R3 positive field");
        send_src(32'h0000_8001, 32'h8000_0000, 3'd4, 3'd3, 1'b0, 1'b1, "R2 R3 top bits");

        // R4..R7, R10: every select code with every fill code
        for (int f = 0; f < 4; f++) begin
            for (int s = 0; s < 7; s++) begin
                if (s == 6) tag = "R10 R4";
                else if (f == 0) tag = "R5 R4";
                else if (f == 1) tag = "R6 R4";
                else tag = "R7 R4";
                send_dst(32'h1234_56F8, 32'hAAAA_5555, 3'(s), 2'(f), tag);
                send_dst(32'h0000_9A3C, 32'h5A5A_C3C3, 3'(s), 2'(f), tag);
            end
        end
        send_dst(32'h0000_00FF, 32'h0000_0000, 3'd7, 2'd1, "R1 R10 code 7");

        // R8: with strobes low, outputs hold while inputs change
        send_src(32'hCAFE_BABE, 32'h0BAD_F00D, 3'd1, 3'd5, 1'b1, 1'b0, "R8 load");
        send_dst(32'h0000_0081, 32'h1111_2222, 3'd2, 2'd1, "R8 load");
        @(negedge clk);
        last_a = opnd_a; last_b = opnd_b; last_m = merge_out;
        for (int k = 0; k < 4; k++) begin
            src_a = $urandom; src_b = $urandom; src_a_sel = 3'(k); src_a_sext = k[0];
            alu_res = $urandom; dst_old = $urandom; dst_sel = 3'(k + 2); dst_fill = 2'(k);
            @(negedge clk);
        end
        check("R8 hold opnd_a", opnd_a, last_a);
        check("R8 hold opnd_b", opnd_b, last_b);
        check("R8 hold merge_out", merge_out, last_m);
        check("R8 strobes idle", {30'd0, opnd_valid, merge_valid}, 32'd0);
        check("R8 scoreboard drained", q_src.size() + q_dst.size(), 32'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule